// File: doc/BRIEF.md
# Block Copy and Compare Sequencer

This block runs the byte-block transfer and byte-block search operations of an 8-bit processor core. A caller loads a source pointer, a destination pointer, a 16-bit count, the accumulator and the current flag byte, picks copy or compare, single or repeating, and upward or downward stepping, then pulses `start`. The sequencer walks memory through a synchronous byte port and reports the updated pointers, count and flag byte, together with the number of T-states the operation would take on the processor and the refresh-counter advance.

Each repeating run is atomic from the caller's view. An early-exit input lets the caller stop a repeat after the current iteration, for example to take an interrupt. In that case the block raises `rewind`, which tells the core to move its program counter back by two so that the instruction runs again later.

Top module: `blk_xfer_seq`

## Requirements
- R1: A copy iteration reads the byte at the source pointer, writes it to the destination pointer, steps both pointers by +1 (`dir_down`=0) or -1 (`dir_down`=1), and decrements the count by one. A compare iteration steps only the source pointer and writes nothing.
- R2: The flag byte uses the layout S=bit7, Z=bit6, Y=bit5, H=bit4, X=bit3, P/V=bit2, N=bit1, C=bit0. A copy keeps S, Z and C from `f_in`, clears H and N, and sets P/V exactly when the count after the decrement is nonzero.
- R3: When `undoc_en`=1, a copy takes X from bit 3 and Y from bit 1 of (byte + A) mod 256. When `undoc_en`=0, X and Y are 0 after a copy.
- R4: A compare forms d = (A - byte) mod 256 and stores nothing. S = d[7], Z = (d==0), H = borrow out of the low nibble, N = 1, C is kept from `f_in`, and P/V = (count after decrement != 0).
- R5: When `undoc_en`=1, a compare takes X from bit 3 and Y from bit 1 of (d - H) mod 256. When `undoc_en`=0, X and Y are 0.
- R6: A repeating copy ends when the count reaches zero. A repeating compare ends when the count reaches zero or d is zero, whichever comes first. A single form always does exactly one iteration.
- R7: `tstates` totals 21 for each iteration after which the run goes on (or is cut short) and 16 for an iteration that ends the run normally. A single form therefore reports 16.
- R8: `refresh_adv` rises by 2 for every iteration executed, modulo 128.
- R9: With `early_exit`=1, a repeat that would continue stops after its current iteration, with P/V set and `rewind`=1. A single form ignores `early_exit` and leaves `rewind`=0.
- R10: A starting count of zero is treated as 65536: the first decrement wraps it to 0xFFFF, and the run continues.
- R11: The memory port makes at most one access per clock. Read data is used one cycle after the read, and a copy's write comes two cycles after its read. `done` pulses for one cycle with `busy` low once the results are final.
- R12: After reset, `busy`, `done`, `mem_re`, `mem_we`, `rewind`, `tstates` and `refresh_adv` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted while idle) |
| op_compare | input | 1 | 1 = compare, 0 = copy |
| op_repeat | input | 1 | 1 = repeating form |
| dir_down | input | 1 | 1 = pointers step down |
| undoc_en | input | 1 | Produce the X/Y flag bits |
| early_exit | input | 1 | Stop a repeat after the current iteration |
| a_in | input | 8 | Accumulator |
| f_in | input | 8 | Flag byte on entry |
| hl_in | input | 16 | Source pointer |
| de_in | input | 16 | Destination pointer |
| bc_in | input | 16 | Count |
| mem_addr | output | 16 | Memory address |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid one cycle after `mem_re` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| hl_out | output | 16 | Source pointer result |
| de_out | output | 16 | Destination pointer result |
| bc_out | output | 16 | Count result |
| f_out | output | 8 | Flag byte result |
| tstates | output | 24 | T-states the operation costs |
| refresh_adv | output | 7 | Refresh counter advance |
| rewind | output | 1 | Repeat was cut short; program counter should step back by 2 |

## Verification
The embedded assertions watch the port discipline on every cycle. They check that a read and a write never happen together, that every write follows its read by two cycles, that the count only ever steps down by one while busy, that `done` arrives with the block idle, and that a repeating copy which is not cut short ends with a zero count. The flag arithmetic, the placement of the match stop, the T-state and refresh totals, and the handling of early exit and a wrapped zero count can only be shown by the bench's sweeps. The bench checks these against a reference model across both directions, both X/Y settings, all four operation forms and several counts and accumulator values.

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int TW = 24,
  parameter int RW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_compare,
  input  logic          op_repeat,
  input  logic          dir_down,
  input  logic          undoc_en,
  input  logic          early_exit,
  input  logic [DW-1:0] a_in,
  input  logic [7:0]    f_in,
  input  logic [AW-1:0] hl_in,
  input  logic [AW-1:0] de_in,
  input  logic [AW-1:0] bc_in,
  output logic [AW-1:0] mem_addr,
  output logic          mem_re,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] hl_out,
  output logic [AW-1:0] de_out,
  output logic [AW-1:0] bc_out,
  output logic [7:0]    f_out,
  output logic [TW-1:0] tstates,
  output logic [RW-1:0] refresh_adv,
  output logic          rewind
);
  localparam logic [TW-1:0] COST_GO  = TW'(21);
  localparam logic [TW-1:0] COST_END = TW'(16);

  typedef enum logic [1:0] {IDLE, RD, EXE, WR} st_t;
  st_t st;

  logic [AW-1:0] hl, de, bc;
  logic [DW-1:0] acc, byte_q;
  logic [7:0]    fl;
  logic          cmp_q, rep_q, dn_q, und_q;

  logic [AW-1:0] step, bc_nx;
  logic [DW-1:0] diff, diff_h, sum;
  logic          hc, upd, more;
  logic [7:0]    f_cp, f_cmp;

  assign step   = dn_q ? '1 : AW'(1);
  assign bc_nx  = bc - AW'(1);
  assign diff   = acc - mem_rdata;
  assign hc     = acc[4] ^ mem_rdata[4] ^ diff[4];
  assign diff_h = diff - DW'(hc);
  assign sum    = byte_q + acc;

  assign f_cp  = {fl[7], fl[6], und_q & sum[1], 1'b0, und_q & sum[3],
                  bc_nx != '0, 1'b0, fl[0]};
  assign f_cmp = {diff[7], diff == '0, und_q & diff_h[1], hc, und_q & diff_h[3],
                  bc_nx != '0, 1'b1, fl[0]};

  assign upd  = (st == EXE && cmp_q) || st == WR;
  assign more = rep_q && bc_nx != '0 && (!cmp_q || diff != '0);

  assign mem_re    = st == RD;
  assign mem_we    = st == WR;
  assign mem_addr  = (st == WR) ? de : hl;
  assign mem_wdata = byte_q;
  assign busy      = st != IDLE;
  assign hl_out    = hl;
  assign de_out    = de;
  assign bc_out    = bc;
  assign f_out     = fl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE;
      hl <= '0; de <= '0; bc <= '0; acc <= '0; fl <= '0; byte_q <= '0;
      cmp_q <= 1'b0; rep_q <= 1'b0; dn_q <= 1'b0; und_q <= 1'b0;
      tstates <= '0; refresh_adv <= '0; rewind <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          hl <= hl_in; de <= de_in; bc <= bc_in; acc <= a_in; fl <= f_in;
          cmp_q <= op_compare; rep_q <= op_repeat; dn_q <= dir_down; und_q <= undoc_en;
          tstates <= '0; refresh_adv <= '0; rewind <= 1'b0;
          st <= RD;
        end
        RD:  st <= EXE;
        EXE: begin
          byte_q <= mem_rdata;
          if (!cmp_q) st <= WR;
        end
        default: ;
      endcase
      if (upd) begin
        bc <= bc_nx;
        hl <= hl + step;
        if (!cmp_q) de <= de + step;
        fl <= cmp_q ? f_cmp : f_cp;
        refresh_adv <= refresh_adv + RW'(2);
        if (more) begin
          tstates <= tstates + COST_GO;
          if (early_exit) begin
            rewind <= 1'b1; done <= 1'b1; st <= IDLE;
          end else st <= RD;
        end else begin
          tstates <= tstates + COST_END;
          done <= 1'b1; st <= IDLE;
        end
      end
    end
  end

  assert_one_access_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));
  assert_write_after_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(mem_re, 2));
  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));
  assert_bc_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && bc != $past(bc)) |-> bc == $past(bc) - AW'(1));
  assert_copy_complete_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !rewind && rep_q && !cmp_q) |-> bc == '0);
endmodule

// File: tb/blk_xfer_seq_test.sv
module blk_xfer_seq_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, start, op_compare, op_repeat, dir_down, undoc_en, early_exit;
  logic [7:0] a_in, f_in, mem_wdata, mem_rdata, f_out;
  logic [15:0] hl_in, de_in, bc_in, mem_addr, hl_out, de_out, bc_out;
  logic mem_re, mem_we, busy, done, rewind;
  logic [23:0] tstates;
  logic [6:0] refresh_adv;

  int checks = 0, errors = 0;
  logic [7:0] mem [0:65535];

  blk_xfer_seq uut (.*);

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr];
  end

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic run(input bit cmp, input bit rep, input bit dn, input bit un, input bit ab,
                     input logic [15:0] hl, input logic [15:0] de, input logic [15:0] bc,
                     input logic [7:0] a, input logic [7:0] f);
    logic [15:0] h, d, b, s;
    logic [7:0] ef, n, z, cn, sm;
    int ts, rf, iters;
    bit pcb, more, hf;
    string rq;
    s = dn ? 16'hFFFF : 16'h0001;
    if (!cmp) for (int j = 0; j < 16; j++) mem[16'(de + s*16'(j))] = ~mem[16'(hl + s*16'(j))];
    h = hl; d = de; b = bc; ef = f; ts = 0; rf = 0; pcb = 0; iters = 0;
    for (int k = 0; k < 70000; k++) begin
      n = mem[h]; b = b - 1; iters++;
      if (cmp) begin
        z = a - n;
        hf = (a & 8'h0F) < (n & 8'h0F);
        cn = z - 8'(hf);
        ef = {z[7], z == 0, un & cn[1], hf, un & cn[3], b != 0, 1'b1, f[0]};
      end else begin
        sm = n + a;
        ef = {f[7], f[6], un & sm[1], 1'b0, un & sm[3], b != 0, 1'b0, f[0]};
        d = d + s;
      end
      h = h + s; rf = rf + 2;
      more = rep && b != 0 && (!cmp || z != 0);
      if (more) begin ts += 21; if (ab) begin pcb = 1; break; end end
      else begin ts += 16; break; end
    end
    @(negedge clk);
    op_compare = cmp; op_repeat = rep; dir_down = dn; undoc_en = un; early_exit = ab;
    hl_in = hl; de_in = de; bc_in = bc; a_in = a; f_in = f; start = 1;
    @(negedge clk); start = 0;
    while (!done) @(negedge clk);
    rq = cmp ? (un ? "R5" : "R4") : (un ? "R3" : "R2");
    chk(rep ? "R6" : "R1", "count", bc_out, b);
    chk("R1", "src ptr", hl_out, h);
    chk("R1", "dst ptr", de_out, d);
    chk(rq, "flags", f_out, ef);
    chk("R7", "tstates", tstates, ts);
    chk("R8", "refresh", refresh_adv, rf & 127);
    chk("R9", "rewind", rewind, pcb);
    chk("R11", "busy at done", busy, 0);
    if (!cmp) for (int j = 0; j < iters && j < 16; j++)
      chk("R1", "copied byte", mem[16'(de + s*16'(j))], mem[16'(hl + s*16'(j))]);
    @(negedge clk);
    chk("R11", "done pulse width", done, 0);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] base, sp;
    logic [7:0] av;
    for (int i = 0; i < 65536; i++) mem[i] = 8'((i * 37 + 11) & 255);
    rst_n = 0; start = 0; op_compare = 0; op_repeat = 0; dir_down = 0; undoc_en = 0;
    early_exit = 0; a_in = 0; f_in = 0; hl_in = 0; de_in = 0; bc_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R12", "busy", busy, 0);
    chk("R12", "done", done, 0);
    chk("R12", "mem strobes", {mem_re, mem_we}, 0);
    chk("R12", "rewind", rewind, 0);
    chk("R12", "tstates", tstates, 0);
    chk("R12", "refresh", refresh_adv, 0);
    for (int op = 0; op < 4; op++)
      for (int dn = 0; dn < 2; dn++)
        for (int un = 0; un < 2; un++)
          for (int ab = 0; ab < 2; ab++)
            for (int bi = 0; bi < 4; bi++)
              for (int ai = 0; ai < 3; ai++) begin
                base = 16'h1040;
                sp = dn ? 16'hFFFF : 16'h0001;
                av = (ai == 0) ? mem[16'(base + sp*2)] : (ai == 1) ? mem[base] : 8'(8'h80 + 8'(bi*17));
                run(op[1], op[0], dn[0], un[0], ab[0], base, 16'h2040,
                    (bi == 0) ? 16'd1 : (bi == 1) ? 16'd2 : (bi == 2) ? 16'd3 : 16'd7,
                    av, 8'(8'hC5 ^ 8'(op*16 + bi)));
              end
    // R10: zero count wraps; early exit keeps the run short
    run(0, 1, 0, 1, 1, 16'h3000, 16'h4000, 16'h0000, 8'h12, 8'hFF);
    run(1, 1, 1, 0, 1, 16'h3000, 16'h4000, 16'h0000, 8'h00, 8'h00);
    chk("R10", "wrapped count", bc_out, 16'hFFFF);
    // R10: zero count, compare that matches on the first byte stops at once
    run(1, 1, 0, 1, 0, 16'h3000, 16'h4000, 16'h0000, mem[16'h3000], 8'h01);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule